// File: doc/BRIEF.md
# Scan-Start Gating Controller

This block decides, one request at a time, whether a periodic scan-start request reaches the acquisition sequencer. A request passes only when an acquisition sequence is running, no software hold is set, no scan is currently under way, and the hardware gate allows it. The qualified start leaves the block as a single-cycle pulse, one clock after the request.

The hardware gate input is asynchronous. It is synchronized on chip, and its active level is chosen by a polarity setting. It works in one of two modes. In level mode, the gate blocks starts for as long as it sits at its active level. In edge mode, each active edge flips an internal enable: the first active edge blocks starts, the next one allows them again, and so on.

Gating is evaluated only at the moment a request arrives. A request is either passed or dropped outright. A dropped request is never held back for later. A scan that has already started is never affected by the gate.

Top module: `scan_gate_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released until the first qualifying request, `start_out` is 0.
- R2: A request cycle (`start_req`=1) that qualifies produces `start_out`=1 exactly one clock later. The pulse lasts for that one cycle only.
- R3: A request made while `seq_active`=0 produces no start.
- R4: A request made while `sw_gate`=1 produces no start.
- R5: A request made while `scan_busy`=1 is dropped. No start overlaps a scan in progress.
- R6: Gate polarity works as follows. With `cfg_active_low`=0 the gate is active when `gate_in`=1. With `cfg_active_low`=1 it is active when `gate_in`=0.
- R7: In level mode (`cfg_edge_mode`=0), a request is dropped while the gate is active. A gate change takes effect no later than three clocks after it reaches `gate_in`.
- R8: In edge mode (`cfg_edge_mode`=1), the enable starts out enabled after reset. Each inactive-to-active gate transition inverts the enable, so the first such transition disables starts and the next one re-enables them. Requests are dropped while the enable is off.
- R9: In edge mode, the gate level itself has no effect. Holding the gate active or inactive changes nothing between active edges.
- R10: A dropped request is never replayed. After the blocking condition clears, no start appears without a new request.
- R11: Leaving edge mode resets the enable to enabled. Level mode is then governed by the gate level alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_req | input | 1 | Raw scan-start request, one request per high cycle |
| gate_in | input | 1 | Asynchronous hardware gate |
| seq_active | input | 1 | Acquisition sequence running |
| sw_gate | input | 1 | Software hold, 1 blocks starts |
| scan_busy | input | 1 | A scan is in progress |
| cfg_edge_mode | input | 1 | 0 selects level mode, 1 selects edge mode |
| cfg_active_low | input | 1 | 1 makes the gate active-low |
| start_out | output | 1 | Qualified scan-start pulse |

## Verification
The assertions check these rules on every cycle: any start must follow a request one clock earlier; it must have been made during an active sequence with no software hold and no busy scan; and in level mode the gate value seen three clocks earlier must have been inactive. The edge-mode toggling, the reset value of the enable, the fact that gate level is ignored between edges, the restore on mode exit and the rule that dropped requests are never replayed all depend on history. Only the bench scenarios show them: they drive gate pulse trains under both polarities and compare against a bench model of the enable.

// File: rtl/scan_gate_pkg.sv
package scan_gate_pkg;

  typedef enum logic {
    GATE_LEVEL = 1'b0,
    GATE_EDGE  = 1'b1
  } gate_mode_e;

  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam int unsigned DEF_RST_STAGES  = 2;

endpackage

// File: rtl/sg_rst_sync.sv
module sg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  localparam int unsigned TOP = STAGES - 1;

  logic [TOP:0] chain_q;
  logic [TOP:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = 1'b1;
    end else begin : g_many
      always_comb chain_d = {chain_q[TOP-1:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[TOP];

endmodule

// File: rtl/sg_gate_track.sv
module sg_gate_track
  import scan_gate_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       gate_raw,
  input  logic       active_low,
  input  gate_mode_e mode,
  output logic       block
);

  localparam int unsigned TOP = SYNC_STAGES - 1;

  // synchronizer chain, stage TOP is the usable copy
  logic [TOP:0] sync_q;
  logic [TOP:0] sync_d;
  logic         prev_q;
  logic         enable_q;
  logic         enable_d;
  logic         enable_ce;

  logic gate_now;
  logic rise_seen;
  logic fall_seen;
  logic active_edge;
  logic level_active;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_comb sync_d = gate_raw;
    end else begin : g_many
      always_comb sync_d = {sync_q[TOP-1:0], gate_raw};
    end
  endgenerate

  assign gate_now = sync_q[TOP];

  // edges are taken on the synchronized raw value so a polarity
  // change never looks like a gate transition
  always_comb begin
    rise_seen    = gate_now & ~prev_q;
    fall_seen    = ~gate_now & prev_q;
    active_edge  = active_low ? fall_seen : rise_seen;
    level_active = gate_now ^ active_low;
  end

  // next-state for the edge-mode enable
  always_comb begin
    enable_ce = 1'b0;
    enable_d  = enable_q;
    if (mode != GATE_EDGE) begin
      enable_ce = ~enable_q;
      enable_d  = 1'b1;
    end else if (active_edge) begin
      enable_ce = 1'b1;
      enable_d  = ~enable_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= gate_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         enable_q <= 1'b1;
    else if (enable_ce) enable_q <= enable_d;
  end

  always_comb begin
    if (mode == GATE_EDGE) block = ~enable_q;
    else                   block = level_active;
  end

endmodule

// File: rtl/sg_start_qual.sv
module sg_start_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic seq_on,
  input  logic sw_hold,
  input  logic busy,
  input  logic hw_block,
  output logic start_pulse
);

  logic pass_d;
  logic pulse_q;

  always_comb begin
    pass_d = req & seq_on & ~sw_hold & ~busy & ~hw_block;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pass_d;
  end

  assign start_pulse = pulse_q;

endmodule

// File: rtl/scan_gate_ctrl.sv
module scan_gate_ctrl
  import scan_gate_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  parameter int unsigned RST_STAGES  = DEF_RST_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic gate_in,
  input  logic seq_active,
  input  logic sw_gate,
  input  logic scan_busy,
  input  logic cfg_edge_mode,
  input  logic cfg_active_low,
  output logic start_out
);

  logic       rst_n_int;
  logic       hw_block;
  gate_mode_e mode;

  assign mode = gate_mode_e'(cfg_edge_mode);

  sg_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  sg_gate_track #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .gate_raw   (gate_in),
    .active_low (cfg_active_low),
    .mode       (mode),
    .block      (hw_block)
  );

  sg_start_qual u_qual (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .req         (start_req),
    .seq_on      (seq_active),
    .sw_hold     (sw_gate),
    .busy        (scan_busy),
    .hw_block    (hw_block),
    .start_pulse (start_out)
  );

endmodule

// File: rtl/scan_gate_chk.sv
module scan_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic start_req,
  input logic gate_in,
  input logic seq_active,
  input logic sw_gate,
  input logic scan_busy,
  input logic cfg_edge_mode,
  input logic cfg_active_low,
  input logic start_out
);

  // cycles since reset release, saturating
  logic [3:0] up_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              up_cnt <= '0;
    else if (up_cnt != 4'hF) up_cnt <= up_cnt + 4'd1;
  end

  AST_START_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (start_out && up_cnt >= 4'd2) |-> $past(start_req)); // R2

  AST_START_IN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (start_out && up_cnt >= 4'd2) |-> $past(seq_active)); // R3

  AST_START_NO_SWHOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (start_out && up_cnt >= 4'd2) |-> !$past(sw_gate)); // R4

  AST_START_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_out && up_cnt >= 4'd2) |-> !$past(scan_busy)); // R5

  AST_LEVEL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_out && up_cnt >= 4'd8 && !$past(cfg_edge_mode))
      |-> ($past(gate_in, 3) == $past(cfg_active_low))); // R7

endmodule

bind scan_gate_ctrl scan_gate_chk u_chk (.*);

// File: tb/sim_scan_gate_ctrl.sv
module sim_scan_gate_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 1'b0;
  logic gate_in = 1'b0;
  logic seq_active = 1'b0;
  logic sw_gate = 1'b0;
  logic scan_busy = 1'b0;
  logic cfg_edge_mode = 1'b0;
  logic cfg_active_low = 1'b0;
  logic start_out;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  logic model_en;

  always #10 clk = ~clk;

  scan_gate_ctrl u0 (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    n_vec = n_vec + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle(2);
    check("R1 in reset", start_out, 1'b0);
    rst_n = 1'b1;
    idle(6);
    check("R1 after release", start_out, 1'b0);
  endtask

  // one request cycle, result checked a clock later, then must drop
  task automatic req_check(input string tag, input logic exp);
    @(negedge clk);
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    check(tag, start_out, exp);
    @(negedge clk);
    check("R2 single pulse", start_out, 1'b0);
  endtask

  task automatic set_gate(input logic active);
    @(negedge clk);
    gate_in = active ^ cfg_active_low;
    idle(4);
  endtask

  initial begin
    do_reset();
    seq_active = 1'b1;
    idle(4);
    req_check("R2 basic pass", 1'b1);

    // exhaustive level-mode sweep: polarity, gate, seq, sw, busy
    for (int v = 0; v < 32; v++) begin
      logic pol, g, sq, sw, bz, exp;
      {pol, g, sq, sw, bz} = v[4:0];
      @(negedge clk);
      cfg_edge_mode = 1'b0;
      cfg_active_low = pol;
      gate_in = g;
      seq_active = sq;
      sw_gate = sw;
      scan_busy = bz;
      idle(4);
      exp = sq & ~sw & ~bz & ~(g ^ pol);
      if (!sq)           req_check("R3 seq gate", exp);
      else if (sw)       req_check("R4 sw gate", exp);
      else if (bz)       req_check("R5 busy drop", exp);
      else if (g ^ pol)  req_check("R6 R7 level mask", exp);
      else               req_check("R6 R7 level open", exp);
    end

    // R10: dropped while masked, then unmask: nothing appears
    @(negedge clk);
    seq_active = 1'b1; sw_gate = 1'b0; scan_busy = 1'b0;
    cfg_active_low = 1'b0; gate_in = 1'b1;
    idle(4);
    req_check("R10 masked drop", 1'b0);
    gate_in = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check("R10 no replay", start_out, 1'b0);
    end

    // edge mode, both polarities
    for (int pol = 0; pol < 2; pol++) begin
      @(negedge clk);
      cfg_edge_mode = 1'b1;
      cfg_active_low = pol[0];
      gate_in = pol[0];
      do_reset();
      model_en = 1'b1;
      req_check("R8 enabled after reset", model_en);
      for (int k = 0; k < 5; k++) begin
        set_gate(1'b1);
        model_en = ~model_en;
        req_check("R8 toggle on active edge", model_en);
        req_check("R9 active level ignored", model_en);
        set_gate(1'b0);
        req_check("R9 inactive edge ignored", model_en);
      end
      // leave enable off, then switch to level mode
      if (model_en) begin
        set_gate(1'b1);
        set_gate(1'b0);
        model_en = 1'b0;
      end
      req_check("R8 disabled", 1'b0);
      @(negedge clk);
      cfg_edge_mode = 1'b0;
      idle(2);
      req_check("R11 level after edge", 1'b1);
      @(negedge clk);
      cfg_edge_mode = 1'b1;
      idle(2);
      req_check("R11 enable restored", 1'b1);
    end

    // R2: back-to-back requests each produce a start
    @(negedge clk);
    cfg_edge_mode = 1'b0;
    gate_in = cfg_active_low;
    idle(4);
    start_req = 1'b1;
    @(negedge clk);
    check("R2 burst first", start_out, 1'b1);
    @(negedge clk);
    start_req = 1'b0;
    check("R2 burst second", start_out, 1'b1);
    @(negedge clk);
    check("R2 burst end", start_out, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule